// File: doc/BRIEF.md
# Dual-Channel Capacitor-Charge Position Digitizer

This block turns two resistive positions into 8-bit numbers by timing how long an external RC network needs to charge up to a trip level. An external comparator watches each capacitor and raises a digital threshold line once the capacitor voltage crosses that level. Inside the block, one free-running counter is shared by both channels. While the counter is in the first half of its range, each channel stores the low counter bits at the moment its threshold line is first seen high. If the line never rises, the channel stores full scale instead, so a missing potentiometer still yields a defined result.

The counter's top bit also drives the discharge output. For the whole second half of the counter's range, that output tells the external switches to empty both capacitors. This gives a fixed frame of 512 clocks with the default width: 256 clocks for charging and measuring, then 256 clocks for discharging. Each threshold line passes through a synchronizer before use. A one-bit select picks which channel's result appears on the read port. Reading is combinational and has no effect on the measurement.

Top module: `rcpot_digitizer`

## Requirements
- R1: The counter runs freely from reset with a period of 512 clocks. `discharge_o` is 0 while the counter value (the frame phase) is 0..255 and 1 while it is 256..511.
- R2: A threshold input that first goes high during the clock in which the phase is `p` is captured as the value `p+2`, because of the two synchronizer flops. This holds for captures up to phase 255. For example, a rise at phase 253 stores 255.
- R3: If a channel has not captured by phase 255, its result is forced to 255 (all ones) at phase 255.
- R4: Each channel captures at most once per frame. If the threshold falls and rises again later in the same frame, the result is not changed.
- R5: During the discharge half (phases 256..511), threshold activity leaves the stored result unchanged.
- R6: The capture flag of each channel clears when the counter wraps from 511 to 0. A threshold that is still high at the wrap is therefore captured as 0 in the new frame.
- R7: A result holds its value across the wrap until that channel's next capture.
- R8: A synchronous active-high `rst` clears the counter, both results and both capture flags. After reset, `discharge_o` is 0 and both channels read 0.
- R9: With `rd_sel_i` equal to 0, `rd_data_o` shows channel 0. With `rd_sel_i` equal to 1, it shows channel 1. The read path is combinational and does not disturb the measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter advances once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| thr_i | input | 2 | Threshold-crossed lines from the external comparators, bit 0 for channel 0 |
| rd_sel_i | input | 1 | Channel select for the read port |
| discharge_o | output | 1 | High while the external capacitors are being emptied |
| rd_data_o | output | 8 | Stored result of the selected channel |

## Verification
The bench builds the block with its default parameters: a 9-bit counter, two channels, two synchronizer stages and forced full scale enabled. With these settings a full 512-clock frame is short enough that several whole frames run in sequence. This brings within reach the capture latency at both ends of the measuring half, the forced 255 result, the clearing of the capture flag at the wrap (a capture at phase 0), and a reset issued in the middle of the discharge half.

// File: rtl/rcpot_pkg.sv
package rcpot_pkg;

   // width of a channel select able to address n channels (never below one bit)
   function automatic int sel_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // default geometry
   localparam int DEF_CNT_W       = 9;
   localparam int DEF_N_CH        = 2;
   localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/rcpot_counter.sv
module rcpot_counter #(
   parameter int CNT_W = rcpot_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt_o,
   output logic             disch_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + STEP;
   end

   assign cnt_o   = cnt_q;
   assign disch_o = cnt_q[CNT_W-1];
   assign wrap_o  = &cnt_q;

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (cnt_q == $past(cnt_q) + STEP));

   // R8
   cnt_clear_chk: assert property (@(posedge clk)
      rst |=> (cnt_q == '0));

endmodule

// File: rtl/rcpot_sync.sv
module rcpot_sync #(
   parameter int STAGES = rcpot_pkg::DEF_SYNC_STAGES
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] pipe_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rcpot_channel.sv
module rcpot_channel #(
   parameter int RES_W      = 8,
   parameter bit FORCE_FULL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [RES_W-1:0] cnt_low_i,
   input  logic             disch_i,
   input  logic             wrap_i,
   input  logic             thr_i,
   output logic [RES_W-1:0] res_o
);

   logic [RES_W-1:0] res_q;
   logic             done_q;
   logic             at_end;
   logic             take;

   generate
      if (FORCE_FULL) begin : g_force
         assign at_end = &cnt_low_i;
      end else begin : g_noforce
         assign at_end = 1'b0;
      end
   endgenerate

   assign take = !disch_i && !done_q && (thr_i || at_end);

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q  <= '0;
         done_q <= 1'b0;
      end else if (take) begin
         res_q  <= cnt_low_i;
         done_q <= 1'b1;
      end else if (wrap_i) begin
         done_q <= 1'b0;
      end
   end

   assign res_o = res_q;

   // R2
   grab_value_chk: assert property (@(posedge clk) disable iff (rst)
      (!disch_i && !done_q && thr_i) |=> (res_q == $past(cnt_low_i)));

   // R4
   single_take_chk: assert property (@(posedge clk) disable iff (rst)
      (done_q && !wrap_i) |=> $stable(res_q));

   // R5
   drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
      disch_i |=> $stable(res_q));

   generate
      if (FORCE_FULL) begin : g_force_chk
         // R3
         full_scale_chk: assert property (@(posedge clk) disable iff (rst)
            (!disch_i && !done_q && (&cnt_low_i)) |=> (&res_q));
      end
   endgenerate

   // R8
   res_clear_chk: assert property (@(posedge clk)
      rst |=> (res_q == '0 && !done_q));

endmodule

// File: rtl/rcpot_digitizer.sv
module rcpot_digitizer #(
   parameter  int CNT_W       = rcpot_pkg::DEF_CNT_W,
   parameter  int N_CH        = rcpot_pkg::DEF_N_CH,
   parameter  int SYNC_STAGES = rcpot_pkg::DEF_SYNC_STAGES,
   parameter  bit FORCE_FULL  = 1'b1,
   localparam int RES_W       = CNT_W - 1,
   localparam int SEL_W       = rcpot_pkg::sel_w(N_CH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_CH-1:0]   thr_i,
   input  logic [SEL_W-1:0]  rd_sel_i,
   output logic              discharge_o,
   output logic [RES_W-1:0]  rd_data_o
);

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("rcpot_digitizer: CNT_W must be at least 3");
      end
      if (N_CH < 1) begin : g_bad_ch
         $error("rcpot_digitizer: N_CH must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("rcpot_digitizer: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             disch;
   logic             wrap;
   logic [N_CH-1:0]  thr_s;
   logic [RES_W-1:0] res_arr [N_CH];

   rcpot_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .cnt_o   (cnt),
      .disch_o (disch),
      .wrap_o  (wrap)
   );

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         rcpot_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d_i (thr_i[g]),
            .q_o (thr_s[g])
         );

         rcpot_channel #(.RES_W(RES_W), .FORCE_FULL(FORCE_FULL)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cnt_low_i (cnt[RES_W-1:0]),
            .disch_i   (disch),
            .wrap_i    (wrap),
            .thr_i     (thr_s[g]),
            .res_o     (res_arr[g])
         );
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (rd_sel_i == SEL_W'(i)) rd_data_o = res_arr[i];
      end
   end

   assign discharge_o = disch;

   // R1
   drain_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (wrap) |=> !discharge_o);

endmodule

// File: tb/rcpot_digitizer_tb.sv
module rcpot_digitizer_tb;
   timeunit 1ns;
   timeprecision 1ps;

   typedef struct {
      int    frame;
      int    ph;
      int    ch;
      int    exp;
      string req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] thr = 2'b00;
   logic       rd_sel = 1'b0;
   logic       dis;
   logic [7:0] rd;

   int    phase  = 0;
   int    frame  = 0;
   int    checks = 0;
   int    errors = 0;
   bit    fin    = 1'b0;
   item_t sb[$];

   always #2.5 clk = ~clk;

   rcpot_digitizer u_dut (
      .clk         (clk),
      .rst         (rst),
      .thr_i       (thr),
      .rd_sel_i    (rd_sel),
      .discharge_o (dis),
      .rd_data_o   (rd)
   );

   // frame-phase model from R1: advances once per clock, wraps at 512
   always @(posedge clk) begin
      if (rst) phase <= 0;
      else if (phase == 511) begin
         phase <= 0;
         frame <= frame + 1;
      end else phase <= phase + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input int f, input int p, input int ch, input int exp, input string req);
      item_t it;
      it.frame = f;
      it.ph    = p;
      it.ch    = ch;
      it.exp   = exp;
      it.req   = req;
      sb.push_back(it);
   endtask

   task automatic wait_at(input int f, input int p);
      do @(negedge clk); while (!(frame == f && phase == p));
   endtask

   // monitor: discharge phase checks and scoreboard reads
   initial begin
      forever begin
         @(negedge clk);
         if (phase == 0 || phase == 255 || phase == 256 || phase == 511)
            chk("R1", int'(dis), (phase >= 256) ? 1 : 0);
         while (sb.size() > 0 && !rst && sb[0].frame == frame && sb[0].ph == phase) begin
            item_t it;
            it = sb.pop_front();
            rd_sel = it.ch[0];
            #0.5;
            chk(it.req, int'(rd), it.exp);
         end
      end
   end

   // driver
   initial begin
      push(0, 1, 0, 0, "R8");
      push(0, 1, 1, 0, "R8");
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // frame 0: channel 0 rises at phase 10, channel 1 never
      push(0, 510, 0, 12, "R2");
      push(0, 510, 1, 255, "R3");
      wait_at(0, 10);  thr[0] = 1'b1;
      wait_at(0, 300); thr[0] = 1'b0;

      // frame 1: result held across wrap, late and early captures, select
      push(1, 5, 0, 12, "R7");
      push(1, 508, 0, 255, "R9");
      push(1, 509, 1, 2, "R9");
      push(1, 510, 0, 255, "R2");
      push(1, 510, 1, 2, "R2");
      wait_at(1, 0);   thr[1] = 1'b1;
      wait_at(1, 253); thr[0] = 1'b1;
      wait_at(1, 300); thr = 2'b00;

      // frame 2: second rise ignored; channel 0 raised in discharge for next frame
      push(2, 510, 0, 52, "R4");
      push(2, 510, 1, 202, "R2");
      wait_at(2, 50);  thr[0] = 1'b1;
      wait_at(2, 60);  thr[0] = 1'b0;
      wait_at(2, 100); thr[0] = 1'b1;
      wait_at(2, 200); thr[1] = 1'b1;
      wait_at(2, 300); thr = 2'b00;
      wait_at(2, 500); thr[0] = 1'b1;

      // frame 3: high at wrap captures 0; discharge pulse on channel 1 ignored
      push(3, 510, 0, 0, "R6");
      push(3, 510, 1, 255, "R5");
      wait_at(3, 100); thr[0] = 1'b0;
      wait_at(3, 300); thr[1] = 1'b1;
      wait_at(3, 310); thr[1] = 1'b0;

      // frame 4: reset in the discharge half
      wait_at(4, 300);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R8", int'(dis), 0);
      push(4, 3, 0, 0, "R8");
      push(4, 3, 1, 0, "R8");
      wait_at(4, 10);

      if (sb.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R9 scoreboard actual %0d pending expected 0", sb.size());
      end
      fin = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // watchdog
   initial begin
      #100us;
      if (!fin) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule